// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block fills the 160-column data latch of a segment-type LCD driver from a narrow parallel bus. Each falling edge of the external shift clock arrives as a one-cycle strobe in the system clock domain. On each strobe the driver takes either 4 or 8 bits, depending on the width mode, and writes them into consecutive columns. A direction input sets whether the fill starts at column 1 and runs upward, or starts at column 160 and runs downward.

Several drivers can share one data bus in a daisy chain. A latch strobe arms every driver. The first driver is selected as soon as its cascade input is seen low on a shift strobe. When its 160 columns are full, it drops out and drives its cascade output low for one shift-clock period, which selects the next driver. The two cascade pins swap between input and output roles with the direction input, so a chain works in either fill direction.

Top module: `lcd_col_loader`

## Requirements
- R1: After reset, all 160 latch bits are 0 and both cascade outputs are high.
- R2: The latch changes only in a cycle that follows a shift strobe. Data bus activity without a strobe has no effect.
- R3: With `wide_mode` low, each accepted strobe loads `din[3:0]` into 4 columns, and `din[7:4]` is ignored. 40 strobes fill the latch.
- R4: With `wide_mode` high, each accepted strobe loads all 8 bits of `din` into 8 columns. 20 strobes fill the latch.
- R5: With `dir_up` high, filling starts at column 1 and rises. Column k is `col_data[k-1]`. Within a word, `din[0]` goes to the lowest column of that word.
- R6: With `dir_up` low, filling starts at column 160 and falls. `din[0]` goes to the highest column of that word.
- R7: With `dir_up` low, `chain_b_in` is the cascade input and `chain_a_out` is the cascade output. With `dir_up` high, `chain_a_in` is the input and `chain_b_out` is the output. The cascade output pin that is not in use is held high.
- R8: Loading begins only after a latch strobe, on the first shift strobe that sees the cascade input low. That strobe's word is loaded. Before any latch strobe, no data is taken.
- R9: Once 160 columns are loaded, the driver is deselected. Further strobes are ignored, even with the cascade input low, until the next latch strobe.
- R10: The cascade output is high while loading. It goes low after the strobe that completes column 160 and returns high after the next shift strobe.
- R11: A latch strobe restarts the column count at the first column and leaves the latch contents unchanged. A shift strobe in the same cycle as a latch strobe is ignored.
- R12: Once the driver is selected, the cascade input is ignored until the fill completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_stb | input | 1 | One-cycle strobe marking a falling edge of the shift clock |
| latch_stb | input | 1 | One-cycle strobe marking a latch pulse |
| wide_mode | input | 1 | 0: 4-bit bus, 1: 8-bit bus |
| dir_up | input | 1 | 1: fill from column 1 up, 0: fill from column 160 down |
| din | input | 8 | Display data bus |
| chain_a_in | input | 1 | Cascade pin A, input side (used when `dir_up`=1) |
| chain_b_in | input | 1 | Cascade pin B, input side (used when `dir_up`=0) |
| chain_a_out | output | 1 | Cascade pin A, output side (active when `dir_up`=0) |
| chain_b_out | output | 1 | Cascade pin B, output side (active when `dir_up`=1) |
| col_data | output | 160 | Column data latch; bit k-1 holds column k |

## Verification
A latch strobe and a shift strobe can arrive in the same cycle. The latch must win: the count restarts, the word on the bus is dropped, and the handoff pulse is cleared. The bench provokes this after a completed fill by raising both strobes together with a distinctive word on the bus. It then checks three things: the latch contents are unchanged, both cascade outputs are high, and the next accepted word lands in the first column. A second overlap, between the strobe that ends the handoff pulse and a stray load attempt with the cascade input low, is judged by confirming that the output returns high and the data stays unchanged.

// File: rtl/colload_pkg.sv
package colload_pkg;

    localparam int IDX_W  = 16;
    localparam int BUS_W  = 8;

    typedef enum logic {
        FILL_DOWN = 1'b0,
        FILL_UP   = 1'b1
    } fill_dir_e;

    typedef enum logic {
        BUS_NARROW = 1'b0,
        BUS_WIDE   = 1'b1
    } bus_mode_e;

    // one write command from the sequencer to the column store
    typedef struct packed {
        logic             take;
        fill_dir_e        dir;
        logic [IDX_W-1:0] base;
        logic [3:0]       step;
    } load_cmd_t;

    function automatic logic [3:0] step_of(bus_mode_e m);
        return (m == BUS_WIDE) ? 4'd8 : 4'd4;
    endfunction

endpackage

// File: rtl/cl_seq.sv
module cl_seq
    import colload_pkg::*;
#(
    parameter int NCOL = 160
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      shift_stb,
    input  logic      latch_stb,
    input  bus_mode_e mode,
    input  fill_dir_e dir,
    input  logic      enab_in,
    output load_cmd_t cmd,
    output logic      handoff
);

    localparam int CW = $clog2(NCOL + BUS_W + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] step_w;
    logic [CW-1:0] next_cnt;
    logic          armed;
    logic          sel;
    logic          take;
    logic          last;

    assign step_w   = CW'(step_of(mode));
    assign next_cnt = cnt + step_w;
    assign last     = (next_cnt >= CW'(NCOL));
    assign take     = shift_stb && !latch_stb && (sel || (armed && !enab_in));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            armed   <= 1'b0;
            sel     <= 1'b0;
            handoff <= 1'b0;
        end else if (latch_stb) begin
            cnt     <= '0;
            armed   <= 1'b1;
            sel     <= 1'b0;
            handoff <= 1'b0;
        end else if (shift_stb) begin
            handoff <= take && last;
            if (take) begin
                cnt   <= next_cnt;
                armed <= 1'b0;
                sel   <= !last;
            end
        end
    end

    always_comb begin
        cmd.take = take;
        cmd.dir  = dir;
        cmd.base = IDX_W'(cnt);
        cmd.step = step_of(mode);
    end

endmodule

// File: rtl/cl_store.sv
module cl_store
    import colload_pkg::*;
#(
    parameter int NCOL = 160
) (
    input  logic             clk,
    input  logic             rst,
    input  load_cmd_t        cmd,
    input  logic [BUS_W-1:0] din,
    output logic [NCOL-1:0]  q
);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [IDX_W-1:0] pos;
        logic [IDX_W-1:0] off;
        logic             hit;

        // position of this column along the current fill order
        assign pos = (cmd.dir == FILL_UP) ? IDX_W'(c) : IDX_W'(NCOL - 1 - c);
        assign off = pos - cmd.base;
        assign hit = cmd.take && (pos >= cmd.base) && (off < IDX_W'(cmd.step));

        always_ff @(posedge clk) begin
            if (rst) begin
                q[c] <= 1'b0;
            end else if (hit) begin
                q[c] <= din[off[2:0]];
            end
        end
    end

endmodule

// File: rtl/lcd_col_loader.sv
module lcd_col_loader
    import colload_pkg::*;
#(
    parameter int NCOL = 160
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_stb,
    input  logic            latch_stb,
    input  logic            wide_mode,
    input  logic            dir_up,
    input  logic [7:0]      din,
    input  logic            chain_a_in,
    input  logic            chain_b_in,
    output logic            chain_a_out,
    output logic            chain_b_out,
    output logic [NCOL-1:0] col_data
);

    fill_dir_e dir;
    bus_mode_e mode;
    logic      enab_in;
    logic      handoff;
    load_cmd_t cmd;

    assign dir     = dir_up    ? FILL_UP  : FILL_DOWN;
    assign mode    = wide_mode ? BUS_WIDE : BUS_NARROW;
    assign enab_in = (dir == FILL_UP) ? chain_a_in : chain_b_in;

    cl_seq #(.NCOL(NCOL)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .shift_stb (shift_stb),
        .latch_stb (latch_stb),
        .mode      (mode),
        .dir       (dir),
        .enab_in   (enab_in),
        .cmd       (cmd),
        .handoff   (handoff)
    );

    cl_store #(.NCOL(NCOL)) u_store (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .din  (din),
        .q    (col_data)
    );

    // cascade output is active low; the spare side idles high
    assign chain_a_out = (dir == FILL_DOWN) ? !handoff : 1'b1;
    assign chain_b_out = (dir == FILL_UP)   ? !handoff : 1'b1;

endmodule

// File: rtl/lcd_col_loader_chk.sv
module lcd_col_loader_chk #(
    parameter int NCOL = 160
) (
    input logic            clk,
    input logic            rst,
    input logic            shift_stb,
    input logic            latch_stb,
    input logic            dir_up,
    input logic            chain_a_out,
    input logic            chain_b_out,
    input logic [NCOL-1:0] col_data
);

    logic eo;
    assign eo = dir_up ? chain_b_out : chain_a_out;

    // R2
    idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_stb |=> $stable(col_data));

    // R11
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> $stable(col_data));

    // R11
    latch_release_chk: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> (chain_a_out && chain_b_out));

    // R10
    hand_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!eo && shift_stb && !latch_stb) |=> eo);

    // R10
    hand_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!eo && !shift_stb && !latch_stb) |=> (!$stable(dir_up) || !eo));

    // R7
    spare_high_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({chain_a_out, chain_b_out}) >= 1);

endmodule

bind lcd_col_loader lcd_col_loader_chk #(.NCOL(NCOL)) u_chk (.*);

// File: tb/tb_lcd_col_loader.sv
module tb_lcd_col_loader;

    localparam int NCOL = 160;

    logic            clk = 1'b0;
    logic            rst;
    logic            shift_stb;
    logic            latch_stb;
    logic            wide_mode;
    logic            dir_up;
    logic [7:0]      din;
    logic            ain;
    logic            bin;
    logic            aout;
    logic            bout;
    logic [NCOL-1:0] col_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    logic [NCOL-1:0] exp_d;
    int  mcnt;
    bit  marmed, msel, mhand;

    always #10 clk = ~clk;

    lcd_col_loader #(.NCOL(NCOL)) dut (
        .clk         (clk),
        .rst         (rst),
        .shift_stb   (shift_stb),
        .latch_stb   (latch_stb),
        .wide_mode   (wide_mode),
        .dir_up      (dir_up),
        .din         (din),
        .chain_a_in  (ain),
        .chain_b_in  (bin),
        .chain_a_out (aout),
        .chain_b_out (bout),
        .col_data    (col_data)
    );

    function automatic logic ein_now();
        return dir_up ? ain : bin;
    endfunction

    task automatic set_ein(input logic v);
        if (dir_up) begin ain = v; bin = 1'b1; end
        else        begin bin = v; ain = 1'b1; end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [NCOL-1:0] act,
                       input logic [NCOL-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_all(input string tag);
        logic eo, spare;
        eo    = dir_up ? bout : aout;
        spare = dir_up ? aout : bout;
        chk(col_data === exp_d, {tag, " data"}, col_data, exp_d);
        chk(eo === !mhand, {tag, " cascade out (R10)"}, NCOL'(eo), NCOL'(!mhand));
        chk(spare === 1'b1, {tag, " spare pin high (R7)"}, NCOL'(spare), NCOL'(1));
    endtask

    task automatic do_shift(input logic [7:0] w, input bit lat);
        @(negedge clk);
        din = w; shift_stb = 1'b1; latch_stb = lat;
        if (lat) begin
            mcnt = 0; marmed = 1; msel = 0; mhand = 0;
        end else begin
            bit take;
            take  = msel || (marmed && !ein_now());
            mhand = 0;
            if (take) begin
                int st;
                st = wide_mode ? 8 : 4;
                for (int i = 0; i < st; i++) begin
                    int col;
                    col = mcnt + i;
                    exp_d[dir_up ? col : NCOL - 1 - col] = w[i];
                end
                mcnt  += st;
                marmed = 0;
                msel   = (mcnt < NCOL);
                mhand  = (mcnt >= NCOL);
            end
        end
        @(negedge clk);
        shift_stb = 1'b0; latch_stb = 1'b0;
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch_stb = 1'b1;
        mcnt = 0; marmed = 1; msel = 0; mhand = 0;
        @(negedge clk);
        latch_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; shift_stb = 0; latch_stb = 0; wide_mode = 1; dir_up = 1;
        din = 8'h00; ain = 1; bin = 1;
        exp_d = '0; mcnt = 0; marmed = 0; msel = 0; mhand = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R8: no latch yet, enable low: nothing taken
        set_ein(1'b0);
        for (int k = 0; k < 3; k++) do_shift(8'hFF, 0);
        check_all("R8 no load before latch");

        for (int cfg = 0; cfg < 4; cfg++) begin
            int st, n;
            wide_mode = cfg[0];
            dir_up    = cfg[1];
            st = wide_mode ? 8 : 4;
            n  = NCOL / st;
            set_ein(1'b1);
            do_latch();
            check_all("R11 after latch");
            // R8: armed but enable high
            do_shift(8'h5A, 0);
            do_shift(8'hC3, 0);
            check_all("R8 waits for enable");
            set_ein(1'b0);
            for (int k = 0; k < n; k++) begin
                logic [7:0] w;
                if (k == 3) set_ein(1'b1);     // R12 enable ignored once selected
                w = 8'((k * 37 + cfg * 11 + 5) ^ (k << 3));
                do_shift(w, 0);
                if (wide_mode) check_all("R4 R5 R6 R12 fill step");
                else           check_all("R3 R5 R6 R12 fill step");
            end
            // R10 low pulse persists until the next strobe; R2 bus noise ignored
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                din = 8'(k * 91 + 7);
                check_all("R2 R10 idle after fill");
            end
            set_ein(1'b0);
            do_shift(8'hE7, 0);
            check_all("R9 R10 strobe after full");
            do_shift(8'h18, 0);
            check_all("R9 ignored after full");
        end

        // R11: latch and shift together, latch wins
        wide_mode = 1; dir_up = 1; set_ein(1'b0);
        do_shift(8'hA5, 1);
        check_all("R11 collision");
        do_shift(8'h3C, 0);
        check_all("R11 restart at column 1");
        chk(col_data[7:0] === 8'h3C, "R11 R5 first word at column 1",
            NCOL'(col_data[7:0]), NCOL'(8'h3C));

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule